// File: doc/BRIEF.md
# TDC Gain Reciprocal Estimator

This block produces the factor that normalizes a time-to-digital converter's output: an estimate of one over the converter's gain. Each reference cycle brings one gain sample and a one-clock strobe. The samples are gathered into blocks of a power-of-two length. A block's mean is formed with a single running sum and a right shift, so no window of past samples is stored. The mean is then saturated into the interval 0.5 to 1.0 and becomes the divisor D.

The reciprocal of D comes from Newton-Raphson refinement. The starting point is the linear guess 48/17 − 32/17·D. Each refinement applies X ← X + X·(1 − D·X). One signed multiplier does all the work. A three-way operand select feeds it the seed product, the error product or the update product, and it takes one step per reference strobe. After three refinement rounds the result is written to the output register, and the valid flag rises. The output then holds until the next block's estimate is ready. A mode input trades settling speed for smoothing by choosing a short or a long averaging block.

Top module: `tdc_gain_recip`

## Requirements
- R1: While reset is asserted, and right after it, `recip_vld` is 0 and `recip_out` is 0.
- R2: The length of an averaging block is chosen by `fast_mode` as sampled at the first strobe of that block: 16 samples when it is 1 and 64 samples when it is 0. Its value at later strobes of the same block has no effect.
- R3: The block mean is the sum of the block's `gain_in` samples, divided by the block length with the remainder dropped. `gain_in` is unsigned with GAIN_FRAC (10) fractional bits.
- R4: The mean is saturated to [0.5, 1.0] before the reciprocal is taken. Codes below 512 behave as 512 (result 2.0) and codes above 1024 behave as 1024 (result 1.0).
- R5: `recip_out` is unsigned with FRAC (13) fractional bits. It is within 4 LSB of 2^13 divided by the saturated mean.
- R6: Once set, `recip_vld` stays 1 until reset. `recip_out` changes only when a new result is written.
- R7: The new result is written at the 7th strobe after the strobe that completes its block: one seed step, then two steps per round for three rounds. The spacing between strobes in clocks does not matter, and back-to-back strobes are allowed.
- R8: When `ref_stb` is 0, `gain_in` and `fast_mode` are ignored, and the estimator state does not advance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_stb | input | 1 | One-clock strobe per reference cycle |
| fast_mode | input | 1 | 1 selects 16-sample blocks, 0 selects 64-sample blocks |
| gain_in | input | 12 | Gain sample, unsigned, 10 fractional bits |
| recip_out | output | 15 | Reciprocal estimate, unsigned, 13 fractional bits |
| recip_vld | output | 1 | Sticky flag: at least one estimate has been written |

## Verification
The assertions assume a new mean never arrives while a refinement is running. This holds because a block spans at least 16 strobes and a computation needs only 7. They also assume the reciprocal stays between just under 1.0 and 2.0, which depends on the saturation ahead of it. The stimulus keeps strobes one clock wide, with irregular spacing that includes back-to-back pairs. It toggles `gain_in` and `fast_mode` randomly between strobes and within blocks. It runs blocks below, inside, above and exactly on the saturation limits, so the range properties are exercised at both ends.

// File: rtl/tgr_pkg.sv
`timescale 1ns/1ps
package tgr_pkg;
    // Step of the refinement sequencer; the encoding doubles as the operand select.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting; a seed multiply happens here when a mean is pending
        PH_ERR  = 2'd1,   // D*X  -> residual
        PH_UPD  = 2'd2    // X*residual -> new X
    } nr_phase_e;
endpackage

// File: rtl/tgr_prog_avg.sv
`timescale 1ns/1ps
module tgr_prog_avg #(
    parameter int GAIN_W  = 12,
    parameter int SH_FAST = 4,
    parameter int SH_SLOW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic              fast,
    input  logic [GAIN_W-1:0] sample,
    output logic              avg_vld,
    output logic [GAIN_W-1:0] avg_val
);
    localparam int SUM_W = GAIN_W + SH_SLOW;
    localparam int CNT_W = SH_SLOW;
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'((1 << SH_FAST) - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'((1 << SH_SLOW) - 1);

    typedef struct packed {
        logic [SUM_W-1:0]  sum;
        logic [CNT_W-1:0]  cnt;
        logic              fast;
        logic              vld;
        logic [GAIN_W-1:0] avg;
    } avg_st_t;

    avg_st_t st_d, st_q;

    always_comb begin
        logic             mode;
        logic [SUM_W-1:0] base;
        logic [SUM_W-1:0] acc;
        logic             last;
        st_d     = st_q;
        st_d.vld = 1'b0;
        mode     = (st_q.cnt == '0) ? fast : st_q.fast;
        base     = (st_q.cnt == '0) ? '0 : st_q.sum;
        acc      = base + {{SH_SLOW{1'b0}}, sample};
        last     = mode ? (st_q.cnt == FAST_LAST) : (st_q.cnt == SLOW_LAST);
        if (stb) begin
            st_d.fast = mode;
            st_d.sum  = acc;
            if (last) begin
                st_d.avg = mode ? GAIN_W'(acc >> SH_FAST) : GAIN_W'(acc >> SH_SLOW);
                st_d.vld = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign avg_vld = st_q.vld;
    assign avg_val = st_q.avg;

    // R2: a fast block never counts past its last sample
    p_fast_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fast |-> (st_q.cnt <= FAST_LAST));
    // R8: a mean is only ever published after a strobe
    p_vld_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> $past(stb));
    // R8: the sample counter is frozen between strobes
    p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(st_q.cnt));
endmodule

// File: rtl/tgr_dclamp.sv
`timescale 1ns/1ps
module tgr_dclamp #(
    parameter int GAIN_W    = 12,
    parameter int GAIN_FRAC = 10,
    parameter int FRAC      = 13,
    parameter int W         = 19
) (
    input  logic [GAIN_W-1:0]   avg,
    output logic signed [W-1:0] d
);
    localparam logic [GAIN_W-1:0] LO = GAIN_W'(1 << (GAIN_FRAC - 1));
    localparam logic [GAIN_W-1:0] HI = GAIN_W'(1 << GAIN_FRAC);

    logic [GAIN_W-1:0] sat;
    logic [W-1:0]      ext;

    always_comb begin
        if (avg < LO)      sat = LO;
        else if (avg > HI) sat = HI;
        else               sat = avg;
        ext = {{(W - GAIN_W){1'b0}}, sat};
    end

    generate
        if (FRAC > GAIN_FRAC) begin : g_align
            assign d = $signed(ext << (FRAC - GAIN_FRAC));
        end else begin : g_same
            assign d = $signed(ext);
        end
    endgenerate
endmodule

// File: rtl/tgr_shared_mul.sv
`timescale 1ns/1ps
module tgr_shared_mul #(
    parameter int W    = 19,
    parameter int FRAC = 13
) (
    input  logic [1:0]          sel,
    input  logic [2:0][W-1:0]   a_arms,
    input  logic [2:0][W-1:0]   b_arms,
    output logic signed [W-1:0] prod
);
    logic signed [W-1:0] a_s, b_s;

    always_comb begin
        a_s = '0;
        b_s = '0;
        for (int k = 0; k < 3; k++) begin
            if (sel == 2'(k)) begin
                a_s = $signed(a_arms[k]);
                b_s = $signed(b_arms[k]);
            end
        end
        prod = W'(($signed({{W{a_s[W-1]}}, a_s}) * $signed({{W{b_s[W-1]}}, b_s})) >>> FRAC);
    end
endmodule

// File: rtl/tgr_nr_seq.sv
`timescale 1ns/1ps
module tgr_nr_seq
    import tgr_pkg::*;
#(
    parameter int W     = 19,
    parameter int FRAC  = 13,
    parameter int ITERS = 3,
    parameter int OUT_W = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic                dnew_vld,
    input  logic signed [W-1:0] dnew,
    output logic [1:0]          sel,
    output logic [2:0][W-1:0]   a_arms,
    output logic [2:0][W-1:0]   b_arms,
    input  logic signed [W-1:0] prod,
    output logic [OUT_W-1:0]    recip,
    output logic                recip_vld
);
    localparam int RND_W = $clog2(ITERS + 1);
    localparam logic [RND_W-1:0]   LAST_RND = RND_W'(ITERS - 1);
    localparam logic signed [W-1:0] ONE_FX  = W'(1 << FRAC);
    localparam logic signed [W-1:0] HALF_FX = W'(1 << (FRAC - 1));
    localparam logic signed [W-1:0] C0_FX   = W'((48 * (1 << FRAC) + 8) / 17);
    localparam logic signed [W-1:0] C1_FX   = W'((32 * (1 << FRAC) + 8) / 17);
    localparam logic [OUT_W-1:0]    OUT_LO  = OUT_W'((1 << FRAC) - 8);
    localparam logic [OUT_W-1:0]    OUT_HI  = OUT_W'(2 << FRAC);

    typedef struct packed {
        nr_phase_e           phase;
        logic                pend;
        logic signed [W-1:0] dnew;
        logic signed [W-1:0] dwork;
        logic signed [W-1:0] x;
        logic signed [W-1:0] e;
        logic [RND_W-1:0]    rounds;
        logic [OUT_W-1:0]    out;
        logic                vld;
    } nr_st_t;

    nr_st_t st_d, st_q;
    logic signed [W-1:0] dsrc;

    assign dsrc = dnew_vld ? dnew : st_q.dnew;

    always_comb begin
        sel       = 2'(st_q.phase);
        a_arms[0] = C1_FX;
        b_arms[0] = dsrc;
        a_arms[1] = st_q.dwork;
        b_arms[1] = st_q.x;
        a_arms[2] = st_q.x;
        b_arms[2] = st_q.e;
    end

    always_comb begin
        logic signed [W-1:0] xn;
        st_d = st_q;
        xn   = st_q.x + prod;
        if (dnew_vld) begin
            st_d.pend = 1'b1;
            st_d.dnew = dnew;
        end
        if (stb) begin
            case (st_q.phase)
                PH_IDLE: begin
                    if (st_q.pend || dnew_vld) begin
                        st_d.dwork  = dsrc;
                        st_d.x      = C0_FX - prod;
                        st_d.pend   = 1'b0;
                        st_d.rounds = '0;
                        st_d.phase  = PH_ERR;
                    end
                end
                PH_ERR: begin
                    st_d.e     = ONE_FX - prod;
                    st_d.phase = PH_UPD;
                end
                PH_UPD: begin
                    st_d.x = xn;
                    if (st_q.rounds == LAST_RND) begin
                        st_d.out   = xn[OUT_W-1:0];
                        st_d.vld   = 1'b1;
                        st_d.phase = PH_IDLE;
                    end else begin
                        st_d.rounds = st_q.rounds + 1'b1;
                        st_d.phase  = PH_ERR;
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign recip     = st_q.out;
    assign recip_vld = st_q.vld;

    // R7: the operand select only ever takes one of the three arms
    p_sel_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel != 2'd3);
    // R8: iterate and residual registers hold between strobes
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(st_q.x) && $stable(st_q.e) && $stable(st_q.phase)));
    // R6: the valid flag never drops outside reset
    p_vld_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |=> st_q.vld);
    // R6: the output moves only on the closing update step
    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_UPD) |=> $stable(st_q.out));
    // R4: the divisor being refined lies inside the saturation range
    p_d_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_IDLE) |-> (st_q.dwork >= HALF_FX && st_q.dwork <= ONE_FX));
    // R5: a published reciprocal lies in [1, 2] up to truncation
    p_out_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.vld |-> (st_q.out >= OUT_LO && st_q.out <= OUT_HI));
endmodule

// File: rtl/tdc_gain_recip.sv
`timescale 1ns/1ps
module tdc_gain_recip #(
    parameter int GAIN_W    = 12,
    parameter int GAIN_FRAC = 10,
    parameter int FRAC      = 13,
    parameter int PROD_INT  = 6,
    parameter int SH_FAST   = 4,
    parameter int SH_SLOW   = 6,
    parameter int ITERS     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_stb,
    input  logic              fast_mode,
    input  logic [GAIN_W-1:0] gain_in,
    output logic [FRAC+1:0]   recip_out,
    output logic              recip_vld
);
    localparam int W     = PROD_INT + FRAC;
    localparam int OUT_W = FRAC + 2;

    logic                avg_vld;
    logic [GAIN_W-1:0]   avg_val;
    logic signed [W-1:0] d_sat;
    logic [1:0]          mul_sel;
    logic [2:0][W-1:0]   a_arms, b_arms;
    logic signed [W-1:0] mul_prod;

    tgr_prog_avg #(.GAIN_W(GAIN_W), .SH_FAST(SH_FAST), .SH_SLOW(SH_SLOW)) u_avg (
        .clk(clk), .rst_n(rst_n), .stb(ref_stb), .fast(fast_mode),
        .sample(gain_in), .avg_vld(avg_vld), .avg_val(avg_val)
    );

    tgr_dclamp #(.GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .FRAC(FRAC), .W(W)) u_clamp (
        .avg(avg_val), .d(d_sat)
    );

    tgr_shared_mul #(.W(W), .FRAC(FRAC)) u_mul (
        .sel(mul_sel), .a_arms(a_arms), .b_arms(b_arms), .prod(mul_prod)
    );

    tgr_nr_seq #(.W(W), .FRAC(FRAC), .ITERS(ITERS), .OUT_W(OUT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .stb(ref_stb),
        .dnew_vld(avg_vld), .dnew(d_sat),
        .sel(mul_sel), .a_arms(a_arms), .b_arms(b_arms), .prod(mul_prod),
        .recip(recip_out), .recip_vld(recip_vld)
    );
endmodule

// File: tb/tdc_gain_recip_test.sv
`timescale 1ns/1ps
module tdc_gain_recip_test;
    localparam int  GW   = 12;
    localparam int  GF   = 10;
    localparam int  FR   = 13;
    localparam real TOL  = 4.0;
    localparam int  LAT  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_stb = 1'b0;
    logic          fast_mode = 1'b0;
    logic [GW-1:0] gain_in = '0;
    logic [FR+1:0] recip_out;
    logic          recip_vld;

    tdc_gain_recip uut (
        .clk(clk), .rst_n(rst_n), .ref_stb(ref_stb), .fast_mode(fast_mode),
        .gain_in(gain_in), .recip_out(recip_out), .recip_vld(recip_vld)
    );

    always #4 clk = ~clk;

    int    n_cmp = 0;
    int    n_bad = 0;
    string tag = "R1 reset";
    bit    started = 1'b0;
    bit    finished = 1'b0;

    // behavioural reference model
    int  m_cnt, m_n, m_sidx, m_due;
    longint m_sum;
    real m_due_val, m_exp_val;
    bit  m_exp_vld, m_upd;
    int  m_last_out;

    always @(posedge clk or negedge rst_n) begin
        m_upd = 1'b0;
        if (!rst_n) begin
            m_cnt = 0; m_n = 16; m_sum = 0; m_sidx = 0; m_due = -1;
            m_exp_vld = 1'b0; m_last_out = 0; m_exp_val = 0.0;
        end else if (ref_stb) begin
            m_sidx++;
            if (m_due == m_sidx) begin
                m_exp_vld = 1'b1;
                m_upd = 1'b1;
                m_exp_val = m_due_val;
                m_due = -1;
            end
            if (m_cnt == 0) begin
                m_n = fast_mode ? 16 : 64;   // R2: length fixed at first sample
                m_sum = 0;
            end
            m_sum += gain_in;
            m_cnt++;
            if (m_cnt == m_n) begin
                longint a;
                a = m_sum / m_n;             // R3: floor of mean
                if (a < 512) a = 512;        // R4: saturate
                if (a > 1024) a = 1024;
                m_due = m_sidx + LAT;        // R7: seven strobes later
                m_due_val = (2.0 ** (FR + GF)) / real'(a);
                m_cnt = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_cmp++;
            if (recip_vld !== m_exp_vld) begin
                n_bad++;
                $display("FAIL R6 [%s] recip_vld actual %0b expected %0b", tag, recip_vld, m_exp_vld);
            end
            n_cmp++;
            if (m_upd) begin
                real diff;
                diff = real'(recip_out) - m_exp_val;
                if (diff < 0.0) diff = -diff;
                if (diff > TOL) begin
                    n_bad++;
                    $display("FAIL R5 [%s] recip_out actual %0d expected %0.2f", tag, recip_out, m_exp_val);
                end
                m_last_out = int'(recip_out);
            end else if (int'(recip_out) !== m_last_out) begin
                n_bad++;
                $display("FAIL R6 [%s] recip_out held actual %0d expected %0d", tag, recip_out, m_last_out);
            end
        end
    end

    // one strobe; gap = extra idle clocks after it (0 = back-to-back)
    task automatic do_stb(input int g, input bit f, input int gap);
        ref_stb = 1'b1; gain_in = GW'(g); fast_mode = f;
        @(posedge clk); #1;
        ref_stb = 1'b0;
        gain_in = GW'($urandom);          // R8: noise between strobes
        fast_mode = 1'($urandom);
        repeat (gap) begin @(posedge clk); #1; end
    endtask

    task automatic run_block(input bit f, input int base, input int spread, input int gap);
        int n;
        n = f ? 16 : 64;
        for (int i = 0; i < n; i++) begin
            int g;
            bit fm;
            g  = base + ((spread > 0) ? int'($urandom % (2 * spread + 1)) - spread : 0);
            fm = (i == 0) ? f : 1'($urandom);   // R2: later mode values ignored
            do_stb(g, fm, (gap < 0) ? int'($urandom % 7) : gap);
        end
    endtask

    initial begin
        #20000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(posedge clk); #1;
        started = 1'b1;
        repeat (3) begin @(posedge clk); #1; end
        rst_n = 1'b1;                          // R1 checked by per-clock compare so far
        tag = "R2 R3 fast 0.75";
        run_block(1'b1, 768, 0, 3);
        tag = "R3 R5 slow noisy 0.88";
        run_block(1'b0, 900, 40, 2);
        tag = "R4 below range";
        run_block(1'b1, 300, 20, 3);
        tag = "R4 above range";
        run_block(1'b1, 2000, 30, 1);
        tag = "R4 exact 0.5";
        run_block(1'b1, 512, 0, 2);
        tag = "R4 exact 1.0";
        run_block(1'b1, 1024, 0, 2);
        tag = "R7 back-to-back strobes";
        run_block(1'b1, 640, 10, 0);
        tag = "R7 R8 irregular gaps";
        run_block(1'b0, 700, 100, -1);
        run_block(1'b1, 980, 30, -1);
        tag = "R5 flush";
        for (int i = 0; i < 8; i++) do_stb(600, 1'b1, 3);
        tag = "R1 R6 mid-run reset";
        rst_n = 1'b0;
        repeat (3) begin @(posedge clk); #1; end
        rst_n = 1'b1;
        tag = "R2 R5 after reset";
        run_block(1'b1, 850, 5, 2);
        for (int i = 0; i < 8; i++) do_stb(850, 1'b0, 2);
        repeat (5) begin @(posedge clk); #1; end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule